// File: doc/BRIEF.md
# Flash Page Mapper with RAM Backfill

This block sits on the memory path of an expansion card and decides, for every host memory cycle, whether the on-card flash answers and, if it does, which 16 KB flash page it answers from. The flash holds up to 32 pages of 16 KB, so the block supplies the five upper flash address bits. The host address lines below bit 14 go straight to the flash. When the flash does not claim the cycle, the block decides whether on-card RAM should fill the hole.

There are three flash windows. The top-of-memory window covers 0xF8000–0xFFFFF and stands in for the system ROM. The remap window is a 16 KB slot in the 0xC0000 segment, and its page comes from a register. The BIOS window is a 16 KB slot in the same segment that always reads page 5. RAM backfill is always on for 128 KB–736 KB. Eight enable bits switch further regions on. Any address that a flash window claims is never also given to RAM.

The address and settings are sampled on a clock edge, and the decision appears on the outputs one clock later.

Top module: `flash_page_mapper`

## Requirements
- R1: While reset is held, and on the first cycle after it, `flash_sel`, `ram_sel` and `flash_page` are all 0.
- R2: If `cyc_valid` is 0 on a clock edge, then after that edge `flash_sel` and `ram_sel` are 0 and `flash_page` is 0, whatever the address. Every decision appears one clock after its inputs are sampled.
- R3: If `top_en` is 1 and the address is in 0xF8000–0xFFFFF, the flash is selected with page = {000, `top_pair`, A14}. So `top_pair`=0 gives pages 0/1 and `top_pair`=1 gives pages 2/3.
- R4: If `remap_en` is 1 and the address is in 0xC0000 + `remap_slot`×0x4000 (a 16 KB range), the flash is selected with page = `remap_page`.
- R5: An address in 0xC0000 + `bios_slot`×0x4000 selects the flash with page 5. The exception is when `bios_off` and `top_en` are both 1: then this window is off.
- R6: Where windows overlap, the top window wins over the remap window, and the remap window wins over the BIOS window.
- R7: Addresses 0x20000–0xB7FFF select RAM, whatever `fill_en` holds.
- R8: Each bit of `fill_en` turns on RAM for its own region:
  - bit0: 0x10000–0x1FFFF
  - bits 1..4: the 16 KB slot at 0xC0000, 0xC4000, 0xC8000 and 0xCC000, in that order
  - bit5: 0xD0000–0xD7FFF and 0xE0000–0xE7FFF
  - bit6: 0xE0000–0xEFFFF
  - bit7: 0xF0000–0xF7FFF
- R9: `flash_sel` and `ram_sel` are never 1 together. An address claimed by an active flash window gives no RAM select, even when its region bit is set.
- R10: An address outside every window and every enabled region (for example 0x00000–0x0FFFF, or 0xB8000–0xBFFFF) selects neither flash nor RAM.
- R11: Whenever `flash_sel` is 0, `flash_page` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_valid | input | 1 | A host memory cycle is present this clock |
| host_addr | input | 20 | Host memory address |
| bios_slot | input | 2 | Switch setting: which 16 KB slot in 0xC0000 holds the BIOS window |
| bios_off | input | 1 | Switch setting: turn off the BIOS window while `top_en` is set |
| top_en | input | 1 | Switch setting: serve 0xF8000–0xFFFFF from flash |
| top_pair | input | 1 | Switch setting: page pair for the top window (0 = pages 0/1, 1 = pages 2/3) |
| remap_en | input | 1 | Control register: remap window on |
| remap_slot | input | 2 | Control register: 16 KB slot of the remap window |
| remap_page | input | 5 | Control register: flash page of the remap window |
| fill_en | input | 8 | Backfill region enable bits |
| flash_sel | output | 1 | Flash chip select |
| flash_page | output | 5 | Flash address bits 18..14 |
| ram_sel | output | 1 | Backfill RAM select |

## Verification
A wrong priority or a wrong slot compare shows up one clock after the address is presented. It appears as the wrong page on `flash_page`, or as `ram_sel` where flash should have answered. Either error can be seen on the very next cycle because the block keeps no state beyond its output register. A stale output register shows up as a select that outlives an idle cycle. The tests therefore pair each window with a set backfill bit over the same slot. They also check the cycle right after reset and right after an idle cycle.

// File: rtl/fpm_pkg.sv
// Shared constants for the flash page mapper.
// Assumes a 20-bit host address space and 16 KB flash pages.
package fpm_pkg;
    localparam int HOST_AW  = 20;
    localparam int PAGE_OFS = 14;                 // bits inside one 16 KB page
    localparam int PAGE_W   = 5;                  // flash A18..A14
    localparam int SLOT_W   = 2;                  // four 16 KB slots per 64 KB segment
    localparam int REGIONS  = 8;                  // switchable backfill regions
    localparam logic [3:0] OPT_SEG = 4'hC;        // segment holding BIOS and remap slots
endpackage

// File: rtl/fpm_window_dec.sv
// Flash window decoder: decides which flash window (if any) claims an
// address and which page it reads. Purely combinational. Assumes the
// top window is the upper 32 KB of the address space and that the
// BIOS and remap windows live in the 0xC0000 segment.
module fpm_window_dec
    import fpm_pkg::*;
#(
    parameter logic [PAGE_W-1:0] BIOS_PAGE = 5
) (
    input  logic [HOST_AW-1:0] addr,
    input  logic [SLOT_W-1:0]  bios_slot,
    input  logic               bios_off,
    input  logic               top_en,
    input  logic               top_pair,
    input  logic               remap_en,
    input  logic [SLOT_W-1:0]  remap_slot,
    input  logic [PAGE_W-1:0]  remap_page,
    output logic               win_hit,
    output logic [PAGE_W-1:0]  win_page
);
    localparam int SEG_LSB = PAGE_OFS + SLOT_W;

    logic in_opt_seg;
    logic top_hit;
    logic remap_hit;
    logic bios_hit;

    // Per-window address match.
    always_comb begin
        in_opt_seg = (addr[HOST_AW-1:SEG_LSB] == OPT_SEG);
        top_hit    = top_en && (&addr[HOST_AW-1:PAGE_OFS+1]);
        remap_hit  = remap_en && in_opt_seg &&
                     (addr[SEG_LSB-1:PAGE_OFS] == remap_slot);
        bios_hit   = !(bios_off && top_en) && in_opt_seg &&
                     (addr[SEG_LSB-1:PAGE_OFS] == bios_slot);
    end

    // Priority resolve: top, then remap, then BIOS.
    always_comb begin
        win_hit  = 1'b0;
        win_page = '0;
        if (top_hit) begin
            win_hit  = 1'b1;
            win_page = {{(PAGE_W-2){1'b0}}, top_pair, addr[PAGE_OFS]};
        end else if (remap_hit) begin
            win_hit  = 1'b1;
            win_page = remap_page;
        end else if (bios_hit) begin
            win_hit  = 1'b1;
            win_page = BIOS_PAGE;
        end
    end
endmodule

// File: rtl/fpm_backfill_dec.sv
// Backfill decoder: reports whether an address falls in the fixed RAM
// range or in any switchable region whose enable bit is set.
// Combinational. Does not know about flash windows; the top module
// applies the exclusion.
module fpm_backfill_dec
    import fpm_pkg::*;
#(
    parameter logic [HOST_AW-1:0] FIXED_LO = 20'h20000,
    parameter logic [HOST_AW-1:0] FIXED_HI = 20'hB8000   // exclusive
) (
    input  logic [HOST_AW-1:0] addr,
    input  logic [REGIONS-1:0] fill_en,
    output logic               fill_hit
);
    localparam int SEG_LSB = PAGE_OFS + SLOT_W;
    localparam int NSLOT   = 1 << SLOT_W;

    logic [REGIONS-1:0] region_hit;
    logic               fixed_hit;

    // Region 0: second 64 KB.
    always_comb region_hit[0] = (addr[HOST_AW-1:SEG_LSB] == 4'h1);

    // Regions 1..4: one per 16 KB slot of the option segment.
    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        localparam logic [SLOT_W-1:0] SLOT = SLOT_W'(k);
        always_comb region_hit[1+k] = (addr[HOST_AW-1:SEG_LSB] == OPT_SEG) &&
                                      (addr[SEG_LSB-1:PAGE_OFS] == SLOT);
    end

    // Regions 5..7: cartridge areas and lower half of the top segment.
    always_comb begin
        region_hit[5] = (addr[HOST_AW-1:PAGE_OFS+1] == 5'h1A) ||
                        (addr[HOST_AW-1:PAGE_OFS+1] == 5'h1C);
        region_hit[6] = (addr[HOST_AW-1:SEG_LSB] == 4'hE);
        region_hit[7] = (addr[HOST_AW-1:PAGE_OFS+1] == 5'h1E);
    end

    // Fixed range plus enabled regions.
    always_comb begin
        fixed_hit = (addr >= FIXED_LO) && (addr < FIXED_HI);
        fill_hit  = fixed_hit || |(region_hit & fill_en);
    end
endmodule

// File: rtl/flash_page_mapper.sv
// Flash page mapper top: samples the host address and settings, combines
// the flash window decision with the backfill decision (flash wins),
// and registers the result, so outputs lag inputs by one clock.
// Synchronous active-low reset clears all outputs.
module flash_page_mapper
    import fpm_pkg::*;
#(
    parameter logic [PAGE_W-1:0] BIOS_PAGE = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cyc_valid,
    input  logic [19:0]        host_addr,
    input  logic [1:0]         bios_slot,
    input  logic               bios_off,
    input  logic               top_en,
    input  logic               top_pair,
    input  logic               remap_en,
    input  logic [1:0]         remap_slot,
    input  logic [4:0]         remap_page,
    input  logic [7:0]         fill_en,
    output logic               flash_sel,
    output logic [4:0]         flash_page,
    output logic               ram_sel
);
    logic              win_hit;
    logic [PAGE_W-1:0] win_page;
    logic              fill_hit;

    fpm_window_dec #(.BIOS_PAGE(BIOS_PAGE)) u_win (
        .addr       (host_addr),
        .bios_slot  (bios_slot),
        .bios_off   (bios_off),
        .top_en     (top_en),
        .top_pair   (top_pair),
        .remap_en   (remap_en),
        .remap_slot (remap_slot),
        .remap_page (remap_page),
        .win_hit    (win_hit),
        .win_page   (win_page)
    );

    fpm_backfill_dec u_fill (
        .addr     (host_addr),
        .fill_en  (fill_en),
        .fill_hit (fill_hit)
    );

    // Output register: flash claim overrides backfill; idle cycles clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flash_sel  <= 1'b0;
            flash_page <= '0;
            ram_sel    <= 1'b0;
        end else begin
            flash_sel  <= cyc_valid && win_hit;
            flash_page <= (cyc_valid && win_hit) ? win_page : '0;
            ram_sel    <= cyc_valid && !win_hit && fill_hit;
        end
    end

    // R9: flash and RAM never selected together.
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(flash_sel && ram_sel));

    // R11: page bits are quiet without a flash select.
    a_r11_page_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_sel |-> (flash_page == '0));

    // R2: an idle cycle yields no select on the next clock.
    a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cyc_valid)) |-> (!flash_sel && !ram_sel));

    // R3: top window returns the chosen pair with A14 as page LSB.
    a_r3_top_page: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cyc_valid) && $past(top_en) &&
         ($past(host_addr) >= 20'hF8000))
        |-> (flash_sel && flash_page == {3'b000, $past(top_pair), $past(host_addr[14])}));

    // R7: the fixed range always reaches RAM.
    a_r7_fixed_fill: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cyc_valid) && ($past(host_addr) >= 20'h20000) &&
         ($past(host_addr) < 20'hB8000)) |-> (ram_sel && !flash_sel));
endmodule

// File: tb/flash_page_mapper_test.sv
module flash_page_mapper_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       cyc_valid;
    logic [19:0] host_addr;
    logic [1:0] bios_slot;
    logic       bios_off;
    logic       top_en;
    logic       top_pair;
    logic       remap_en;
    logic [1:0] remap_slot;
    logic [4:0] remap_page;
    logic [7:0] fill_en;
    logic       flash_sel;
    logic [4:0] flash_page;
    logic       ram_sel;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    flash_page_mapper uut (
        .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .host_addr(host_addr),
        .bios_slot(bios_slot), .bios_off(bios_off), .top_en(top_en),
        .top_pair(top_pair), .remap_en(remap_en), .remap_slot(remap_slot),
        .remap_page(remap_page), .fill_en(fill_en), .flash_sel(flash_sel),
        .flash_page(flash_page), .ram_sel(ram_sel)
    );

    // Compare outputs against expected values, at a falling edge.
    task automatic expect_out(input string tag, input logic e_cs,
                              input logic [4:0] e_pg, input logic e_ram);
        checks++;
        if (flash_sel !== e_cs || flash_page !== e_pg || ram_sel !== e_ram) begin
            errors++;
            $display("FAIL %s: got cs=%0b page=%0d ram=%0b, expected cs=%0b page=%0d ram=%0b",
                     tag, flash_sel, flash_page, ram_sel, e_cs, e_pg, e_ram);
        end
    endtask

    // Present one address for one clock and check the registered result.
    task automatic access(input string tag, input logic [19:0] a, input logic e_cs,
                          input logic [4:0] e_pg, input logic e_ram);
        @(negedge clk);
        cyc_valid = 1'b1;
        host_addr = a;
        @(negedge clk);
        expect_out(tag, e_cs, e_pg, e_ram);
    endtask

    task automatic defaults();
        bios_slot = 2'd0; bios_off = 1'b0; top_en = 1'b0; top_pair = 1'b0;
        remap_en = 1'b0; remap_slot = 2'd0; remap_page = 5'd0; fill_en = 8'h00;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; cyc_valid = 1'b1; host_addr = 20'h30000; defaults();
        repeat (3) @(negedge clk);
        expect_out("R1 in reset", 1'b0, 5'd0, 1'b0);
        rst_n = 1'b1;
        cyc_valid = 1'b0;
        @(negedge clk);
        expect_out("R1 first cycle after reset", 1'b0, 5'd0, 1'b0);
    endtask

    task automatic t_idle();
        defaults(); top_en = 1'b1; fill_en = 8'hFF;
        access("R2 live cycle before idle", 20'h40000, 1'b0, 5'd0, 1'b1);
        @(negedge clk);
        cyc_valid = 1'b0; host_addr = 20'hF8000;
        @(negedge clk);
        expect_out("R2 idle top address", 1'b0, 5'd0, 1'b0);
        host_addr = 20'h50000;
        @(negedge clk);
        expect_out("R2 idle fixed-fill address", 1'b0, 5'd0, 1'b0);
    endtask

    task automatic t_top();
        defaults(); top_en = 1'b1;
        access("R3 pair0 even page", 20'hF8000, 1'b1, 5'd0, 1'b0);
        access("R3 pair0 odd page",  20'hFC000, 1'b1, 5'd1, 1'b0);
        top_pair = 1'b1;
        access("R3 pair1 even page", 20'hFBFFF, 1'b1, 5'd2, 1'b0);
        access("R3 pair1 odd page",  20'hFFFFF, 1'b1, 5'd3, 1'b0);
        top_en = 1'b0; fill_en = 8'hFF;
        access("R3 top off no claim", 20'hF8000, 1'b0, 5'd0, 1'b0);
    endtask

    task automatic t_remap();
        defaults(); remap_en = 1'b1; remap_slot = 2'd2; remap_page = 5'h13;
        bios_slot = 2'd0;
        access("R4 remap slot2", 20'hC8010, 1'b1, 5'h13, 1'b0);
        remap_page = 5'h1F;
        access("R4 remap page change", 20'hCBFFF, 1'b1, 5'h1F, 1'b0);
        access("R4 outside remap slot", 20'hCC000, 1'b0, 5'd0, 1'b0);
        remap_en = 1'b0; fill_en = 8'b0000_1000;
        access("R4 remap off falls to fill", 20'hC8010, 1'b0, 5'd0, 1'b1);
    endtask

    task automatic t_bios();
        defaults(); bios_slot = 2'd1;
        access("R5 bios slot1", 20'hC4000, 1'b1, 5'd5, 1'b0);
        bios_off = 1'b1;
        access("R5 bios_off alone keeps window", 20'hC7FFF, 1'b1, 5'd5, 1'b0);
        top_en = 1'b1; fill_en = 8'b0000_0100;
        access("R5 bios_off with top drops window", 20'hC4000, 1'b0, 5'd0, 1'b1);
    endtask

    task automatic t_priority();
        defaults(); bios_slot = 2'd3; remap_en = 1'b1; remap_slot = 2'd3;
        remap_page = 5'd9;
        access("R6 remap over bios", 20'hCC100, 1'b1, 5'd9, 1'b0);
        remap_slot = 2'd0;
        access("R6 bios when remap elsewhere", 20'hCC100, 1'b1, 5'd5, 1'b0);
    endtask

    task automatic t_fixed();
        defaults();
        access("R7 fixed low edge",  20'h20000, 1'b0, 5'd0, 1'b1);
        access("R7 fixed high edge", 20'hB7FFF, 1'b0, 5'd0, 1'b1);
        access("R10 just past fixed", 20'hB8000, 1'b0, 5'd0, 1'b0);
        access("R10 region0 off",     20'h1FFFF, 1'b0, 5'd0, 1'b0);
    endtask

    task automatic t_regions();
        defaults(); fill_en = 8'b0000_0001;
        access("R8 bit0", 20'h10000, 1'b0, 5'd0, 1'b1);
        fill_en = 8'b0001_0000;
        access("R8 bit4 slot CC000", 20'hCC000, 1'b0, 5'd0, 1'b1);
        access("R8 bit4 not C8000",  20'hC8000, 1'b0, 5'd0, 1'b0);
        fill_en = 8'b0010_0000;
        access("R8 bit5 D0000", 20'hD0000, 1'b0, 5'd0, 1'b1);
        access("R8 bit5 E7FFF", 20'hE7FFF, 1'b0, 5'd0, 1'b1);
        access("R8 bit5 not D8000", 20'hD8000, 1'b0, 5'd0, 1'b0);
        fill_en = 8'b0100_0000;
        access("R8 bit6 E8000", 20'hE8000, 1'b0, 5'd0, 1'b1);
        fill_en = 8'b1000_0000;
        access("R8 bit7 F0000", 20'hF0000, 1'b0, 5'd0, 1'b1);
        access("R8 bit7 not F8000", 20'hF8000, 1'b0, 5'd0, 1'b0);
    endtask

    task automatic t_exclusion();
        defaults(); fill_en = 8'hFF; bios_slot = 2'd0;
        remap_en = 1'b1; remap_slot = 2'd1; remap_page = 5'd7;
        access("R9 remap beats fill",  20'hC4000, 1'b1, 5'd7, 1'b0);
        access("R9 bios beats fill",   20'hC0000, 1'b1, 5'd5, 1'b0);
        access("R9 free slot fills",   20'hC8000, 1'b0, 5'd0, 1'b1);
        access("R10 low memory",       20'h05000, 1'b0, 5'd0, 1'b0);
        access("R11 page zero on fill", 20'hB0000, 1'b0, 5'd0, 1'b1);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_idle();
                t_top();
                t_remap();
                t_bios();
                t_priority();
                t_fixed();
                t_regions();
                t_exclusion();
            end
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: got timeout, expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule